// File: doc/BRIEF.md
# E1 Frame Alignment Tracker

This block takes a received 2.048 Mbit/s E1 bit stream, one bit for each cycle in which a bit enable is high, and finds and holds basic frame alignment on its 256-bit frames. While aligned it reports the position of the most recently accepted bit within the frame, the time slot that bit belongs to, and whether the bit lies in an alignment-word frame (even) or in a non-alignment frame (odd). Every output is registered and changes only on a clock edge where the bit enable is high.

To find alignment it first searches for the 7-bit alignment word. It then confirms bit 2 of the following frame and checks for the word again one frame later. Once aligned, repeated bad alignment words send it back to search. A selectable second rule also counts bad bit-2 values in non-alignment frames. Two further outputs serve the rest of the receive path. One is a link-clock strobe that can be opened separately for each of the five national bit positions. The other is a carrier-loss flag raised by a long run of received zeros.

Top module: `e1_frame_sync`

## Requirements
- R1: After synchronous reset, in_sync, odd_frame, link_clk and carrier_lost are 0 and bit_pos is 0.
- R2: Alignment is declared only when the word 0011011 fills frame positions 1 to 7 in frame N (the first bit sent sits at position 1), position 1 of frame N+1 holds a 1, and the word is present again in frame N+2. in_sync rises on the edge that accepts position 7 of frame N+2, with bit_pos = 7 and odd_frame = 0.
- R3: During search, a 0 at position 1 of the frame after a candidate word, or a wrong word two frames after it, abandons the candidate with in_sync held at 0. The search carries on with the next bit, and a later valid three-frame sequence still gives alignment.
- R4: While aligned, bit_pos advances by one for each accepted bit, modulo 256. ts_idx equals bit_pos divided by 8. odd_frame toggles when bit_pos wraps from 255 to 0. None of these change while bit_en is low.
- R5: Once aligned, three consecutive even frames with a wrong word at positions 1 to 7 drop in_sync on the edge that accepts position 7 of the third such frame. A correct word in between restarts the count.
- R6: With alt_resync = 1, three consecutive odd frames whose position 1 holds a 0 also drop in_sync, on the edge that accepts position 1 of the third such frame. With alt_resync = 0 these errors have no effect.
- R7: carrier_lost goes to 1 on the edge that accepts the 255th consecutive zero when cfg_ctrl[0] = 0, and on the 2048th when cfg_ctrl[0] = 1.
- R8: carrier_lost returns to 0 on the edge that accepts the first 1 bit. The zero-run count saturates, so carrier_lost stays at 1 through any longer zero run.
- R9: link_clk is 1 for an accepted bit only when the block is aligned, the frame is odd, bit_pos is between 3 and 7, and the enable bit cfg_ctrl[bit_pos] is set. cfg_ctrl[3] to cfg_ctrl[7] enable the Sa4 to Sa8 positions. In every other case link_clk is 0, including throughout loss of alignment.
- R10: The reserved bits cfg_ctrl[2:1] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Received data bit |
| alt_resync | input | 1 | Adds odd-frame bit-2 errors to the loss rule |
| cfg_ctrl | input | 8 | [0] long zero-run threshold, [2:1] reserved, [7:3] Sa4..Sa8 strobe enables |
| in_sync | output | 1 | Frame alignment held |
| bit_pos | output | 8 | Frame position of last accepted bit |
| ts_idx | output | 5 | Time slot of last accepted bit |
| odd_frame | output | 1 | Last accepted bit lies in a non-alignment frame |
| link_clk | output | 1 | Link-clock strobe at the enabled Sa positions |
| carrier_lost | output | 1 | Zero run reached the selected threshold |

## Verification
The assertions check several properties on every cycle. Alignment can only rise at position 7 of an even frame and can only fall at one of the two check positions. The position counter steps by one and wraps with a frame parity toggle while aligned, and every output holds while no bit is accepted. The strobe only ever appears in an aligned odd frame at positions 3 to 7, and a received 1 always clears carrier loss. The bench scenarios are needed for the behaviour that depends on history: the three-frame confirmation, abandoned candidates during search, and the count of three errors with its reset by a good word. They are also needed for the effect of the alternate rule, the exact zero-run lengths under each threshold, saturation, and the reserved bits having no effect.

// File: rtl/e1fs_pkg.sv
package e1fs_pkg;

  typedef enum logic [1:0] {
    ST_HUNT     = 2'd0,
    ST_CHK_ODD  = 2'd1,
    ST_CHK_EVEN = 2'd2,
    ST_LOCKED   = 2'd3
  } align_st_e;

  localparam int        WORD_W   = 7;
  localparam logic [6:0] SYNC_WORD = 7'b0011011;

  // Frame positions where the alignment checks land.
  localparam int WORD_END_POS = 7;
  localparam int ODD_CHK_POS  = 1;

  // Control byte layout.
  localparam int CFG_W        = 8;
  localparam int CFG_LONG_BIT = 0;
  localparam int CFG_SA_LO    = 3;
  localparam int SA_COUNT     = 5;

endpackage

// File: rtl/e1fs_word_det.sv
module e1fs_word_det
  import e1fs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  output logic word_hit
);

  logic [WORD_W-2:0] hist_q;
  logic [WORD_W-1:0] window;

  // Oldest bit at the top, bit arriving this cycle at the bottom.
  assign window   = {hist_q, bit_in};
  assign word_hit = (window == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (bit_en) begin
      hist_q <= window[WORD_W-2:0];
    end
  end

endmodule

// File: rtl/e1fs_align_fsm.sv
module e1fs_align_fsm
  import e1fs_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int LOSS_COUNT = 3,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int ERR_W     = $clog2(LOSS_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             word_hit,
  input  logic             alt_resync,
  output logic [POS_W-1:0] pos_q,
  output logic             odd_q,
  output logic             lock_q,
  output logic [POS_W-1:0] pos_n,
  output logic             odd_n,
  output logic             lock_n
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] END_POS  = POS_W'(WORD_END_POS);
  localparam logic [POS_W-1:0] CHK_POS  = POS_W'(ODD_CHK_POS);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_COUNT - 1);

  align_st_e        st_q, st_n;
  logic [ERR_W-1:0] even_err_q, even_err_n;
  logic [ERR_W-1:0] odd_err_q, odd_err_n;

  logic [POS_W-1:0] pos_inc;
  logic             odd_inc;
  logic             at_even_chk;
  logic             at_odd_chk;

  always_comb begin
    pos_inc     = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    odd_inc     = (pos_q == LAST_POS) ? ~odd_q : odd_q;
    at_even_chk = (pos_inc == END_POS) && !odd_inc;
    at_odd_chk  = (pos_inc == CHK_POS) && odd_inc;

    st_n       = st_q;
    pos_n      = pos_q;
    odd_n      = odd_q;
    even_err_n = even_err_q;
    odd_err_n  = odd_err_q;

    if (bit_en) begin
      pos_n = pos_inc;
      odd_n = odd_inc;
      unique case (st_q)
        ST_HUNT: begin
          if (word_hit) begin
            st_n  = ST_CHK_ODD;
            pos_n = END_POS;
            odd_n = 1'b0;
          end
        end
        ST_CHK_ODD: begin
          if (at_odd_chk) begin
            st_n = bit_in ? ST_CHK_EVEN : ST_HUNT;
          end
        end
        ST_CHK_EVEN: begin
          if (at_even_chk) begin
            st_n       = word_hit ? ST_LOCKED : ST_HUNT;
            even_err_n = '0;
            odd_err_n  = '0;
          end
        end
        ST_LOCKED: begin
          if (at_even_chk) begin
            if (word_hit) begin
              even_err_n = '0;
            end else if (even_err_q == ERR_LAST) begin
              even_err_n = '0;
              st_n       = ST_HUNT;
            end else begin
              even_err_n = even_err_q + 1'b1;
            end
          end
          if (!alt_resync) begin
            odd_err_n = '0;
          end else if (at_odd_chk) begin
            if (bit_in) begin
              odd_err_n = '0;
            end else if (odd_err_q == ERR_LAST) begin
              odd_err_n = '0;
              st_n      = ST_HUNT;
            end else begin
              odd_err_n = odd_err_q + 1'b1;
            end
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
    lock_n = (st_n == ST_LOCKED);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HUNT;
      pos_q      <= '0;
      odd_q      <= 1'b0;
      lock_q     <= 1'b0;
      even_err_q <= '0;
      odd_err_q  <= '0;
    end else begin
      st_q       <= st_n;
      pos_q      <= pos_n;
      odd_q      <= odd_n;
      lock_q     <= lock_n;
      even_err_q <= even_err_n;
      odd_err_q  <= odd_err_n;
    end
  end

endmodule

// File: rtl/e1fs_sa_strobe.sv
module e1fs_sa_strobe
  import e1fs_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic [POS_W-1:0]    pos_n,
  input  logic                odd_n,
  input  logic                lock_n,
  input  logic [SA_COUNT-1:0] sa_sel,
  output logic                strobe_q
);

  logic [SA_COUNT-1:0] slot_hit;

  for (genvar k = 0; k < SA_COUNT; k++) begin : g_sa
    assign slot_hit[k] = sa_sel[k] && (pos_n == POS_W'(CFG_SA_LO + k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
    end else if (bit_en) begin
      strobe_q <= lock_n && odd_n && (|slot_hit);
    end
  end

endmodule

// File: rtl/e1fs_zero_run.sv
module e1fs_zero_run #(
  parameter int SHORT_RUN = 255,
  parameter int LONG_RUN  = 2048,
  localparam int CNT_W    = $clog2(LONG_RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  input  logic long_sel,
  output logic lost_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_RUN);
  localparam logic [CNT_W-1:0] THR_S   = CNT_W'(SHORT_RUN);

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_n;
  logic [CNT_W-1:0] limit;

  assign run_n = (run_q == CNT_MAX) ? run_q : run_q + 1'b1;
  assign limit = long_sel ? CNT_MAX : THR_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      lost_q <= 1'b0;
    end else if (bit_en) begin
      if (bit_in) begin
        run_q  <= '0;
        lost_q <= 1'b0;
      end else begin
        run_q  <= run_n;
        lost_q <= (run_n >= limit);
      end
    end
  end

endmodule

// File: rtl/e1_frame_sync.sv
module e1_frame_sync
  import e1fs_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 8,
  parameter int LOSS_COUNT = 3,
  parameter int SHORT_RUN  = 255,
  parameter int LONG_RUN   = 2048,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int SLOT_SH   = $clog2(SLOT_BITS),
  localparam int TS_W      = POS_W - SLOT_SH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             alt_resync,
  input  logic [CFG_W-1:0] cfg_ctrl,
  output logic             in_sync,
  output logic [POS_W-1:0] bit_pos,
  output logic [TS_W-1:0]  ts_idx,
  output logic             odd_frame,
  output logic             link_clk,
  output logic             carrier_lost
);

  logic             word_hit;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             odd_q, odd_n;
  logic             lock_q, lock_n;
  logic             cfg_rsvd_unused;

  assign cfg_rsvd_unused = ^cfg_ctrl[CFG_SA_LO-1:CFG_LONG_BIT+1];

  e1fs_word_det u_word (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .word_hit (word_hit)
  );

  e1fs_align_fsm #(
    .FRAME_BITS (FRAME_BITS),
    .LOSS_COUNT (LOSS_COUNT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .word_hit   (word_hit),
    .alt_resync (alt_resync),
    .pos_q      (pos_q),
    .odd_q      (odd_q),
    .lock_q     (lock_q),
    .pos_n      (pos_n),
    .odd_n      (odd_n),
    .lock_n     (lock_n)
  );

  e1fs_sa_strobe #(
    .POS_W (POS_W)
  ) u_sa (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .pos_n    (pos_n),
    .odd_n    (odd_n),
    .lock_n   (lock_n),
    .sa_sel   (cfg_ctrl[CFG_SA_LO +: SA_COUNT]),
    .strobe_q (link_clk)
  );

  e1fs_zero_run #(
    .SHORT_RUN (SHORT_RUN),
    .LONG_RUN  (LONG_RUN)
  ) u_zero (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .bit_in   (bit_in),
    .long_sel (cfg_ctrl[CFG_LONG_BIT]),
    .lost_q   (carrier_lost)
  );

  assign in_sync   = lock_q;
  assign bit_pos   = pos_q;
  assign odd_frame = odd_q;
  assign ts_idx    = pos_q[POS_W-1:SLOT_SH];

endmodule

// File: rtl/e1_frame_sync_chk.sv
module e1_frame_sync_chk #(
  parameter int POS_W = 8,
  parameter int TS_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             bit_in,
  input logic             in_sync,
  input logic [POS_W-1:0] bit_pos,
  input logic [TS_W-1:0]  ts_idx,
  input logic             odd_frame,
  input logic             link_clk,
  input logic             carrier_lost
);

  a_r2_lock_on_even_word: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> (bit_pos == POS_W'(7)) && !odd_frame);

  // R5 and R6: loss lands on one of the two check positions
  a_r5_drop_at_check: assert property (@(posedge clk) disable iff (rst)
    $fell(in_sync) |-> ((bit_pos == POS_W'(7)) && !odd_frame) ||
                       ((bit_pos == POS_W'(1)) && odd_frame));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (in_sync && bit_en) |=> !in_sync || (bit_pos == POS_W'($past(bit_pos) + 1'b1)));

  a_r4_parity_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_sync && bit_en && (&bit_pos)) |=> !in_sync || (odd_frame != $past(odd_frame)));

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(bit_pos) && $stable(ts_idx) && $stable(in_sync) && $stable(odd_frame)
                && $stable(link_clk) && $stable(carrier_lost));

  a_r9_strobe_window: assert property (@(posedge clk) disable iff (rst)
    link_clk |-> in_sync && odd_frame && (ts_idx == '0) &&
                 (bit_pos >= POS_W'(3)) && (bit_pos <= POS_W'(7)));

  a_r8_one_clears: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_in) |=> !carrier_lost);

  a_r7_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_lost) |-> $past(bit_en) && !$past(bit_in));

endmodule

bind e1_frame_sync e1_frame_sync_chk #(
  .POS_W (POS_W),
  .TS_W  (TS_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_en       (bit_en),
  .bit_in       (bit_in),
  .in_sync      (in_sync),
  .bit_pos      (bit_pos),
  .ts_idx       (ts_idx),
  .odd_frame    (odd_frame),
  .link_clk     (link_clk),
  .carrier_lost (carrier_lost)
);

// File: tb/e1_frame_sync_tb.sv
`timescale 1ns/1ps
module e1_frame_sync_tb;

  localparam logic [6:0] WORD = 7'b0011011;
  localparam int K_SYNC = 0, K_POS = 1, K_TS = 2, K_ODD = 3, K_LCLK = 4, K_LOST = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b1;
  logic       alt_resync = 1'b0;
  logic [7:0] cfg_ctrl = 8'h00;
  logic       in_sync, odd_frame, link_clk, carrier_lost;
  logic [7:0] bit_pos;
  logic [4:0] ts_idx;

  int total = 0;
  int bad = 0;
  int     qk[$];
  int     qe[$];
  string  qr[$];

  always #4 clk = ~clk;

  e1_frame_sync u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .alt_resync(alt_resync), .cfg_ctrl(cfg_ctrl),
    .in_sync(in_sync), .bit_pos(bit_pos), .ts_idx(ts_idx),
    .odd_frame(odd_frame), .link_clk(link_clk), .carrier_lost(carrier_lost)
  );

  function automatic int actual(int kind);
    case (kind)
      K_SYNC: return int'(in_sync);
      K_POS:  return int'(bit_pos);
      K_TS:   return int'(ts_idx);
      K_ODD:  return int'(odd_frame);
      K_LCLK: return int'(link_clk);
      default: return int'(carrier_lost);
    endcase
  endfunction

  function automatic string kname(int kind);
    case (kind)
      K_SYNC: return "in_sync";
      K_POS:  return "bit_pos";
      K_TS:   return "ts_idx";
      K_ODD:  return "odd_frame";
      K_LCLK: return "link_clk";
      default: return "carrier_lost";
    endcase
  endfunction

  task automatic compare(int kind, int exp, string req);
    int got;
    got = actual(kind);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", req, kname(kind), got, exp, $time);
    end
  endtask

  task automatic push(int kind, int exp, string req);
    qk.push_back(kind);
    qe.push_back(exp);
    qr.push_back(req);
  endtask

  // Monitor: after each accepted bit, compare everything queued for it.
  initial begin
    forever begin
      @(posedge clk iff bit_en);
      @(negedge clk);
      while (qk.size() > 0) begin
        compare(qk.pop_front(), qe.pop_front(), qr.pop_front());
      end
    end
  end

  task automatic send(bit b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    #1;
  endtask

  function automatic bit fbit(bit odd, bit good, int p);
    if (p == 0) return 1'b1;
    if (!odd) begin
      if (p <= 7) return good ? WORD[7-p] : ~WORD[7-p];
      return 1'b1;
    end
    if (p == 1) return good;
    if (p == 2) return 1'b0;
    return 1'b1;
  endfunction

  // s_before/s_after: expected in_sync before/from position chg (-1: unchecked).
  task automatic send_frame(bit odd, bit good, int s_before, int s_after, int chg,
                            bit chk_lclk, string req);
    for (int p = 0; p < 256; p++) begin
      int es;
      es = (p < chg) ? s_before : s_after;
      if (s_before >= 0) begin
        push(K_SYNC, es, req);
        if (es == 1) begin
          push(K_POS, p, "R4");
          push(K_TS, p / 8, "R4");
          push(K_ODD, int'(odd), "R4");
        end
        if (chk_lclk)
          push(K_LCLK, int'((es == 1) && odd && p >= 3 && p <= 7 && cfg_ctrl[p % 8]), "R9");
      end
      send(fbit(odd, good, p));
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired got=%0d exp=%0d", wd, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare(K_SYNC, 0, "R1");
    compare(K_POS, 0, "R1");
    compare(K_ODD, 0, "R1");
    compare(K_LCLK, 0, "R1");
    compare(K_LOST, 0, "R1");

    // Acquisition; reserved bits set throughout (R10). Sa4, Sa6, Sa8 enabled.
    cfg_ctrl = 8'b1010_1110;
    send_frame(1'b0, 1'b1, 0, 0, 0, 1'b0, "R2");
    send_frame(1'b1, 1'b1, 0, 0, 0, 1'b1, "R2");
    send_frame(1'b0, 1'b1, 0, 1, 7, 1'b1, "R2");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b1, "R9");
    cfg_ctrl = 8'b0101_0000;
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b1, "R4");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b1, "R9");
    repeat (4) @(negedge clk);
    compare(K_POS, 255, "R4");
    compare(K_ODD, 1, "R4");

    // Bad alignment words: count, reset by a good word, then loss.
    cfg_ctrl = 8'b1111_1000;
    send_frame(1'b0, 1'b0, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b0, 1'b0, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b0, 1'b0, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b0, 1'b0, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b1, 1'b1, 1, 1, 0, 1'b0, "R5");
    send_frame(1'b0, 1'b0, 1, 0, 7, 1'b0, "R5");
    send_frame(1'b1, 1'b1, 0, 0, 0, 1'b1, "R9");

    // Search with failed confirmations.
    send_frame(1'b0, 1'b1, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b1, 1'b0, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b0, 1'b1, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b1, 1'b1, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b0, 1'b0, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b1, 1'b1, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b0, 1'b1, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b1, 1'b1, 0, 0, 0, 1'b0, "R3");
    send_frame(1'b0, 1'b1, 0, 1, 7, 1'b0, "R3");

    // Odd-frame bit-2 errors, ignored then counted.
    alt_resync = 1'b0;
    send_frame(1'b1, 1'b0, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b1, 1'b0, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b1, 1'b0, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b0, "R6");
    alt_resync = 1'b1;
    send_frame(1'b1, 1'b0, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b1, 1'b0, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b0, 1'b1, 1, 1, 0, 1'b0, "R6");
    send_frame(1'b1, 1'b0, 1, 0, 1, 1'b0, "R6");

    // Zero runs, short threshold.
    cfg_ctrl = 8'h00;
    for (int i = 1; i <= 300; i++) begin
      if (i == 254) push(K_LOST, 0, "R7");
      if (i == 255) push(K_LOST, 1, "R7");
      if (i == 300) push(K_LOST, 1, "R8");
      send(1'b0);
    end
    push(K_LOST, 0, "R8");
    send(1'b1);

    // Long threshold and saturation.
    cfg_ctrl = 8'h01;
    for (int i = 1; i <= 2600; i++) begin
      if (i == 255)  push(K_LOST, 0, "R7");
      if (i == 2047) push(K_LOST, 0, "R7");
      if (i == 2048) push(K_LOST, 1, "R7");
      if (i == 2600) push(K_LOST, 1, "R8");
      send(1'b0);
    end
    push(K_LOST, 0, "R8");
    send(1'b1);

    // Reserved bits set with the short threshold.
    cfg_ctrl = 8'b0000_0110;
    for (int i = 1; i <= 255; i++) begin
      if (i == 254) push(K_LOST, 0, "R10");
      if (i == 255) push(K_LOST, 1, "R10");
      send(1'b0);
    end
    push(K_LOST, 0, "R10");
    send(1'b1);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule